// File: doc/BRIEF.md
# Ping-Pong Buffer Handoff Controller

This block coordinates a byte-stream producer (a DMA engine moving data from a serial or parallel port) with a packet consumer (the USB buffer manager that sends bulk data to the host). There are two packet buffers, X and Y. The block holds a small descriptor for each buffer: a NAK bit that says who owns the buffer, and a byte count. While the NAK bit is 1 the producer owns the buffer and fills it. The producer gives up ownership by posting a count and clearing the NAK bit. The consumer sends the posted buffer, then sets the NAK bit again, which hands the buffer back.

Software sets a transaction timeout limit and raises the channel enable. From then on the producer fills X, Y, X and so on, and the consumer drains them in the same order, following a select bit that it toggles itself. No further software action is needed. If the producer moves on to a buffer that the consumer has not yet handed back, it stalls. A millisecond timer that is reloaded on every accepted byte ends the transfer when the stream goes quiet. Any partly filled buffer is then posted with its real length.

The buffer memory is outside the block. The block drives a write port that carries buffer select, address and data.

Top module: `pp_handoff_ctrl`

## Requirements
- R1: After reset both NAK bits are 1, both counts are 0, `cons_valid` is 0, and the fill and drain selects both point at X (select value 0 = X, 1 = Y). `src_ready` is 0 while `chan_en` is 0.
- R2: Each accepted byte (`src_valid` and `src_ready` both high) appears in the same cycle on the write port. `wr_sel` is the buffer being filled, and `wr_addr` runs 0, 1, 2 and so on within that buffer.
- R3: When byte number PKT_BYTES of a buffer is accepted, the next cycle shows that buffer's count equal to PKT_BYTES and its NAK bit 0. Filling continues in the other buffer from address 0.
- R4: `cons_valid` is high exactly when the NAK bit of the buffer named by `cons_sel` is 0, and `cons_count` shows that buffer's count. A `cons_done` pulse while `cons_valid` is high sets that NAK bit to 1 and toggles `cons_sel` in the next cycle. A `cons_done` pulse while `cons_valid` is low changes nothing.
- R5: While the buffer being filled has its NAK bit at 0, `src_ready` is 0 and no byte is written.
- R6: If the consumer releases a buffer in the same cycle that the producer completes the other buffer and switches to it, the producer accepts a byte into the released buffer in the very next cycle, at address 0.
- R7: With `tmo_en` high, every accepted byte loads the timer with `tmo_limit`. The timer counts down by one on each `tick_ms`. With a limit L of 1 or more, the L-th tick after the last byte halts the channel; a limit of 0 halts on the first tick. The timer does not run before the first byte that follows enabling, and it never halts while `tmo_en` is 0.
- R8: A `tick_ms` that arrives in the same cycle as an accepted byte is absorbed by the reload and does not shorten the timeout.
- R9: On a halt, `halted` rises and `src_ready` stays 0. If the current buffer holds N > 0 bytes, that buffer is posted with count N and NAK 0, `partial_pulse` is high for one cycle, and the fill select moves on. If the buffer is empty, nothing is posted and there is no pulse.
- R10: Dropping `chan_en` for a cycle clears `halted`, discards a partly filled buffer (the next byte goes to address 0), and disarms the timer. Selects and descriptors are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| chan_en | input | 1 | Channel enable from software |
| tmo_en | input | 1 | Timeout counter enable |
| tmo_limit | input | TMO_W | Timeout in milliseconds |
| tick_ms | input | 1 | One-cycle pulse per millisecond (start of frame) |
| src_valid | input | 1 | Producer offers a byte |
| src_data | input | DATA_W | Offered byte |
| src_ready | output | 1 | Byte is accepted this cycle |
| wr_en | output | 1 | Buffer write strobe |
| wr_sel | output | 1 | Buffer written (0 = X, 1 = Y) |
| wr_addr | output | $clog2(PKT_BYTES) | Byte address inside the buffer |
| wr_data | output | DATA_W | Byte written |
| nak_x | output | 1 | Descriptor NAK bit of X |
| nak_y | output | 1 | Descriptor NAK bit of Y |
| cnt_x | output | $clog2(PKT_BYTES+1) | Descriptor byte count of X |
| cnt_y | output | $clog2(PKT_BYTES+1) | Descriptor byte count of Y |
| cons_sel | output | 1 | Consumer X/Y select |
| cons_valid | output | 1 | Buffer at `cons_sel` is ready to send |
| cons_count | output | $clog2(PKT_BYTES+1) | Byte count of that buffer |
| cons_done | input | 1 | Consumer finished sending, releases buffer |
| partial_pulse | output | 1 | Short buffer posted on timeout |
| halted | output | 1 | Channel stopped by timeout |

## Verification
Two collisions are provoked on purpose. In the first, the consumer's release of X falls in the same cycle as the producer's last byte into Y. The bench then expects no stall cycle: the next byte must land at X address 0. In the second, a millisecond tick coincides with an accepted byte. The bench then counts the further ticks to the halt and expects the full limit, not one fewer. The halt point is also swept over every timeout limit of a reduced configuration, with partial buffers of different lengths, and each expected tick number and posted count is computed arithmetically.

// File: rtl/pp_handoff_pkg.sv
package pp_handoff_pkg;
   localparam logic SEL_X = 1'b0;
   localparam logic SEL_Y = 1'b1;
   localparam int   NUM_BUFS = 2;

   function automatic logic flip_sel(input logic s);
      return ~s;
   endfunction
endpackage

// File: rtl/pp_fill_engine.sv
module pp_fill_engine
   import pp_handoff_pkg::*;
#(
   parameter int PKT_BYTES = 64,
   localparam int PTR_W = $clog2(PKT_BYTES),
   localparam int CNT_W = $clog2(PKT_BYTES + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 chan_en,
   input  logic                 src_valid,
   input  logic [NUM_BUFS-1:0]  nak_vec,
   input  logic                 expire,
   output logic                 src_ready,
   output logic                 accept,
   output logic                 fill_sel,
   output logic [PTR_W-1:0]     fill_ptr,
   output logic                 post_en,
   output logic                 post_sel,
   output logic [CNT_W-1:0]     post_cnt,
   output logic                 partial_pulse,
   output logic                 halted
);
   localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(PKT_BYTES - 1);
   localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(PKT_BYTES);

   logic             sel_q;
   logic [PTR_W-1:0] ptr_q;
   logic             halted_q;
   logic             pulse_q;
   logic             run;
   logic             at_last;
   logic             post_full;
   logic             post_part;

   assign run       = chan_en & ~halted_q;
   assign src_ready = run & nak_vec[sel_q];
   assign accept    = src_valid & src_ready;
   assign at_last   = (ptr_q == LAST_PTR);
   assign post_full = accept & at_last;
   assign post_part = expire & (ptr_q != '0);
   assign post_en   = post_full | post_part;
   assign post_sel  = sel_q;
   assign post_cnt  = post_full ? FULL_CNT : CNT_W'(ptr_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q    <= SEL_X;
         ptr_q    <= '0;
         halted_q <= 1'b0;
         pulse_q  <= 1'b0;
      end else begin
         pulse_q <= post_part;
         if (!chan_en) begin
            ptr_q    <= '0;
            halted_q <= 1'b0;
         end else begin
            if (expire) begin
               halted_q <= 1'b1;
               ptr_q    <= '0;
            end
            if (post_en) begin
               sel_q <= flip_sel(sel_q);
            end
            if (accept) begin
               ptr_q <= at_last ? '0 : ptr_q + 1'b1;
            end
         end
      end
   end

   assign fill_sel      = sel_q;
   assign fill_ptr      = ptr_q;
   assign partial_pulse = pulse_q;
   assign halted        = halted_q;
endmodule

// File: rtl/pp_txn_timer.sv
module pp_txn_timer #(
   parameter int TMO_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             chan_en,
   input  logic             halted,
   input  logic             tmo_en,
   input  logic [TMO_W-1:0] tmo_limit,
   input  logic             tick_ms,
   input  logic             accept,
   output logic             expire
);
   logic [TMO_W-1:0] cnt_q;
   logic             armed_q;
   logic             load;

   assign load   = accept & tmo_en;
   assign expire = chan_en & ~halted & tmo_en & armed_q & tick_ms & ~load
                   & (cnt_q <= TMO_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         armed_q <= 1'b0;
      end else if (!chan_en) begin
         armed_q <= 1'b0;
      end else if (load) begin
         cnt_q   <= tmo_limit;
         armed_q <= 1'b1;
      end else if (tick_ms && armed_q && tmo_en && cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end
endmodule

// File: rtl/pp_desc_bank.sv
module pp_desc_bank
   import pp_handoff_pkg::*;
#(
   parameter int CNT_W = 7
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               post_en,
   input  logic                               post_sel,
   input  logic [CNT_W-1:0]                   post_cnt,
   input  logic                               rel_en,
   input  logic                               rel_sel,
   output logic [NUM_BUFS-1:0]                nak_vec,
   output logic [NUM_BUFS-1:0][CNT_W-1:0]     cnt_vec
);
   for (genvar g = 0; g < NUM_BUFS; g++) begin : g_slot
      logic             nak_q;
      logic [CNT_W-1:0] cnt_q;
      logic             hit_post;
      logic             hit_rel;

      assign hit_post = post_en && (post_sel == g[0]);
      assign hit_rel  = rel_en && (rel_sel == g[0]);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            nak_q <= 1'b1;
            cnt_q <= '0;
         end else if (hit_post) begin
            nak_q <= 1'b0;
            cnt_q <= post_cnt;
         end else if (hit_rel) begin
            nak_q <= 1'b1;
         end
      end

      assign nak_vec[g] = nak_q;
      assign cnt_vec[g] = cnt_q;
   end
endmodule

// File: rtl/pp_drain_port.sv
module pp_drain_port
   import pp_handoff_pkg::*;
#(
   parameter int CNT_W = 7
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            cons_done,
   input  logic [NUM_BUFS-1:0]             nak_vec,
   input  logic [NUM_BUFS-1:0][CNT_W-1:0]  cnt_vec,
   output logic                            cons_sel,
   output logic                            cons_valid,
   output logic [CNT_W-1:0]                cons_count,
   output logic                            rel_en
);
   logic sel_q;

   assign cons_valid = ~nak_vec[sel_q];
   assign cons_count = cnt_vec[sel_q];
   assign rel_en     = cons_done & cons_valid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q <= SEL_X;
      end else if (rel_en) begin
         sel_q <= flip_sel(sel_q);
      end
   end

   assign cons_sel = sel_q;
endmodule

// File: rtl/pp_handoff_ctrl.sv
module pp_handoff_ctrl
   import pp_handoff_pkg::*;
#(
   parameter int PKT_BYTES = 64,
   parameter int DATA_W    = 8,
   parameter int TMO_W     = 5,
   localparam int PTR_W    = $clog2(PKT_BYTES),
   localparam int CNT_W    = $clog2(PKT_BYTES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              chan_en,
   input  logic              tmo_en,
   input  logic [TMO_W-1:0]  tmo_limit,
   input  logic              tick_ms,
   input  logic              src_valid,
   input  logic [DATA_W-1:0] src_data,
   output logic              src_ready,
   output logic              wr_en,
   output logic              wr_sel,
   output logic [PTR_W-1:0]  wr_addr,
   output logic [DATA_W-1:0] wr_data,
   output logic              nak_x,
   output logic              nak_y,
   output logic [CNT_W-1:0]  cnt_x,
   output logic [CNT_W-1:0]  cnt_y,
   output logic              cons_sel,
   output logic              cons_valid,
   output logic [CNT_W-1:0]  cons_count,
   input  logic              cons_done,
   output logic              partial_pulse,
   output logic              halted
);
   if (PKT_BYTES < 2) begin : g_bad_pkt
      $error("pp_handoff_ctrl: PKT_BYTES must be at least 2");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("pp_handoff_ctrl: DATA_W must be at least 1");
   end
   if (TMO_W < 1) begin : g_bad_tmo
      $error("pp_handoff_ctrl: TMO_W must be at least 1");
   end

   logic [NUM_BUFS-1:0]            nak_vec;
   logic [NUM_BUFS-1:0][CNT_W-1:0] cnt_vec;
   logic                           accept;
   logic                           expire;
   logic                           fill_sel;
   logic [PTR_W-1:0]               fill_ptr;
   logic                           post_en;
   logic                           post_sel;
   logic [CNT_W-1:0]               post_cnt;
   logic                           rel_en;
   logic                           halted_int;

   pp_fill_engine #(.PKT_BYTES(PKT_BYTES)) u_fill (
      .clk           (clk),
      .rst_n         (rst_n),
      .chan_en       (chan_en),
      .src_valid     (src_valid),
      .nak_vec       (nak_vec),
      .expire        (expire),
      .src_ready     (src_ready),
      .accept        (accept),
      .fill_sel      (fill_sel),
      .fill_ptr      (fill_ptr),
      .post_en       (post_en),
      .post_sel      (post_sel),
      .post_cnt      (post_cnt),
      .partial_pulse (partial_pulse),
      .halted        (halted_int)
   );

   pp_txn_timer #(.TMO_W(TMO_W)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .chan_en   (chan_en),
      .halted    (halted_int),
      .tmo_en    (tmo_en),
      .tmo_limit (tmo_limit),
      .tick_ms   (tick_ms),
      .accept    (accept),
      .expire    (expire)
   );

   pp_desc_bank #(.CNT_W(CNT_W)) u_desc (
      .clk      (clk),
      .rst_n    (rst_n),
      .post_en  (post_en),
      .post_sel (post_sel),
      .post_cnt (post_cnt),
      .rel_en   (rel_en),
      .rel_sel  (cons_sel),
      .nak_vec  (nak_vec),
      .cnt_vec  (cnt_vec)
   );

   pp_drain_port #(.CNT_W(CNT_W)) u_drain (
      .clk        (clk),
      .rst_n      (rst_n),
      .cons_done  (cons_done),
      .nak_vec    (nak_vec),
      .cnt_vec    (cnt_vec),
      .cons_sel   (cons_sel),
      .cons_valid (cons_valid),
      .cons_count (cons_count),
      .rel_en     (rel_en)
   );

   assign wr_en   = accept;
   assign wr_sel  = fill_sel;
   assign wr_addr = fill_ptr;
   assign wr_data = src_data;
   assign nak_x   = nak_vec[SEL_X];
   assign nak_y   = nak_vec[SEL_Y];
   assign cnt_x   = cnt_vec[SEL_X];
   assign cnt_y   = cnt_vec[SEL_Y];
   assign halted  = halted_int;
endmodule

// File: rtl/pp_handoff_chk.sv
module pp_handoff_chk #(
   parameter int PKT_BYTES = 64,
   parameter int TMO_W     = 5,
   localparam int PTR_W    = $clog2(PKT_BYTES),
   localparam int CNT_W    = $clog2(PKT_BYTES + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tmo_en,
   input logic             tick_ms,
   input logic             wr_en,
   input logic             wr_sel,
   input logic [PTR_W-1:0] wr_addr,
   input logic             nak_x,
   input logic             nak_y,
   input logic [CNT_W-1:0] cnt_x,
   input logic             cons_sel,
   input logic             cons_valid,
   input logic             cons_done,
   input logic             partial_pulse,
   input logic             halted
);
   localparam logic [PTR_W-1:0] LAST = PTR_W'(PKT_BYTES - 1);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(PKT_BYTES);

   assert_x_post_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(nak_x) |-> (partial_pulse || $past(wr_en && !wr_sel && wr_addr == LAST)));

   assert_x_full_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(nak_x) && !partial_pulse) |-> (cnt_x == FULL));

   assert_x_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(nak_x) |-> $past(cons_done && cons_valid && !cons_sel));

   assert_sel_toggle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cons_sel != $past(cons_sel)) |-> $past(cons_done && cons_valid));

   assert_no_write_owned_x_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_sel) |-> nak_x);

   assert_no_write_owned_y_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel) |-> nak_y);

   assert_halt_on_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(halted) |-> $past(tick_ms && tmo_en));

   assert_no_write_halted_R9: assert property (@(posedge clk) disable iff (!rst_n)
      halted |-> !wr_en);

   assert_pulse_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      partial_pulse |=> !partial_pulse);

   assert_pulse_with_halt_R9: assert property (@(posedge clk) disable iff (!rst_n)
      partial_pulse |-> halted);
endmodule

bind pp_handoff_ctrl pp_handoff_chk #(.PKT_BYTES(PKT_BYTES), .TMO_W(TMO_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .tmo_en        (tmo_en),
   .tick_ms       (tick_ms),
   .wr_en         (wr_en),
   .wr_sel        (wr_sel),
   .wr_addr       (wr_addr),
   .nak_x         (nak_x),
   .nak_y         (nak_y),
   .cnt_x         (cnt_x),
   .cons_sel      (cons_sel),
   .cons_valid    (cons_valid),
   .cons_done     (cons_done),
   .partial_pulse (partial_pulse),
   .halted        (halted)
);

// File: tb/pp_handoff_ctrl_bench.sv
module pp_handoff_ctrl_bench;
   localparam int PKT   = 8;
   localparam int DW    = 8;
   localparam int TW    = 3;
   localparam int PW    = $clog2(PKT);
   localparam int CW    = $clog2(PKT + 1);

   logic          clk = 1'b0;
   logic          rst_n;
   logic          chan_en, tmo_en, tick_ms, src_valid, cons_done;
   logic [TW-1:0] tmo_limit;
   logic [DW-1:0] src_data;
   logic          src_ready, wr_en, wr_sel, nak_x, nak_y;
   logic          cons_sel, cons_valid, partial_pulse, halted;
   logic [PW-1:0] wr_addr;
   logic [DW-1:0] wr_data;
   logic [CW-1:0] cnt_x, cnt_y, cons_count;

   int n_chk = 0;
   int n_bad = 0;
   int exp_sel = 0;

   always #10 clk = ~clk;

   pp_handoff_ctrl #(.PKT_BYTES(PKT), .DATA_W(DW), .TMO_W(TW)) u_pp_handoff_ctrl (
      .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .tmo_en(tmo_en),
      .tmo_limit(tmo_limit), .tick_ms(tick_ms), .src_valid(src_valid),
      .src_data(src_data), .src_ready(src_ready), .wr_en(wr_en),
      .wr_sel(wr_sel), .wr_addr(wr_addr), .wr_data(wr_data),
      .nak_x(nak_x), .nak_y(nak_y), .cnt_x(cnt_x), .cnt_y(cnt_y),
      .cons_sel(cons_sel), .cons_valid(cons_valid), .cons_count(cons_count),
      .cons_done(cons_done), .partial_pulse(partial_pulse), .halted(halted)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s act=%0d exp=%0d", req, act, exp);
      end
   endtask

   function automatic int nak_of(input int s);
      return (s == 0) ? int'(nak_x) : int'(nak_y);
   endfunction

   function automatic int cnt_of(input int s);
      return (s == 0) ? int'(cnt_x) : int'(cnt_y);
   endfunction

   // called at a negedge; returns at the next negedge
   task automatic push(input int d, input int sel, input int addr, input string req);
      src_valid = 1'b1;
      src_data  = DW'(d);
      #2;
      chk({req, " wr_en"}, int'(wr_en), 1);
      chk({req, " wr_sel"}, int'(wr_sel), sel);
      chk({req, " wr_addr"}, int'(wr_addr), addr);
      chk({req, " wr_data"}, int'(wr_data), d & 8'hFF);
      @(negedge clk);
      src_valid = 1'b0;
   endtask

   task automatic tick1();
      tick_ms = 1'b1;
      @(negedge clk);
      tick_ms = 1'b0;
   endtask

   task automatic release1();
      cons_done = 1'b1;
      @(negedge clk);
      cons_done = 1'b0;
   endtask

   task automatic rearm(input logic en_t, input int lim);
      chan_en = 1'b0;
      @(negedge clk);
      chk("R10 halted cleared", int'(halted), 0);
      chan_en   = 1'b1;
      tmo_en    = en_t;
      tmo_limit = TW'(lim);
   endtask

   task automatic finish_run();
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL R1 watchdog act=hung exp=finished");
      finish_run();
   end

   initial begin
      rst_n = 1'b0; chan_en = 1'b0; tmo_en = 1'b0; tmo_limit = '0;
      tick_ms = 1'b0; src_valid = 1'b0; src_data = '0; cons_done = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      chk("R1 nak_x", int'(nak_x), 1);
      chk("R1 nak_y", int'(nak_y), 1);
      chk("R1 cnt_x", int'(cnt_x), 0);
      chk("R1 cnt_y", int'(cnt_y), 0);
      chk("R1 cons_valid", int'(cons_valid), 0);
      chk("R1 cons_sel", int'(cons_sel), 0);
      chk("R1 src_ready off", int'(src_ready), 0);

      chan_en = 1'b1;
      for (int i = 0; i < PKT; i++) push(i + 16, 0, i, "R2 fill X");
      chk("R3 nak_x posted", int'(nak_x), 0);
      chk("R3 cnt_x full", int'(cnt_x), PKT);
      chk("R4 cons_valid", int'(cons_valid), 1);
      chk("R4 cons_count", int'(cons_count), PKT);
      for (int i = 0; i < PKT; i++) push(i + 64, 1, i, "R3 fill Y");
      chk("R3 nak_y posted", int'(nak_y), 0);
      chk("R3 cnt_y full", int'(cnt_y), PKT);

      chk("R5 stalled", int'(src_ready), 0);
      for (int i = 0; i < 3; i++) begin
         src_valid = 1'b1;
         #2;
         chk("R5 no write while stalled", int'(wr_en), 0);
         @(negedge clk);
      end
      src_valid = 1'b0;

      release1();
      chk("R4 release X nak", int'(nak_x), 1);
      chk("R4 cons_sel to Y", int'(cons_sel), 1);
      chk("R5 resumes", int'(src_ready), 1);
      release1();
      chk("R4 release Y nak", int'(nak_y), 1);
      chk("R4 cons_sel to X", int'(cons_sel), 0);
      release1();
      chk("R4 ignored done sel", int'(cons_sel), 0);
      chk("R4 ignored done nak_x", int'(nak_x), 1);
      chk("R4 ignored done valid", int'(cons_valid), 0);

      // R6: release X while last byte of Y is taken
      for (int i = 0; i < PKT; i++) push(i, 0, i, "R6 fill X");
      for (int i = 0; i < PKT - 1; i++) push(i, 1, i, "R6 fill Y");
      cons_done = 1'b1;
      push(99, 1, PKT - 1, "R6 last Y");
      cons_done = 1'b0;
      chk("R6 nak_x released", int'(nak_x), 1);
      chk("R6 nak_y posted", int'(nak_y), 0);
      chk("R6 cons_sel", int'(cons_sel), 1);
      chk("R6 no stall", int'(src_ready), 1);
      push(7, 0, 0, "R6 next into X");
      release1();
      chk("R4 Y drained", int'(nak_y), 1);

      // R7/R9/R10: timeout sweep over all limits
      exp_sel = 0;
      for (int lim = 0; lim < (1 << TW); lim++) begin
         automatic int k   = (lim % 3) + 1;
         automatic int n_t = (lim == 0) ? 1 : lim;
         rearm(1'b1, lim);
         for (int b = 0; b < k; b++) push(b + lim, exp_sel, b, "R10 restart addr");
         for (int t = 1; t <= n_t; t++) begin
            tick1();
            if (t < n_t) chk("R7 not yet halted", int'(halted), 0);
         end
         chk("R7 halted at limit", int'(halted), 1);
         chk("R9 partial pulse", int'(partial_pulse), 1);
         chk("R9 partial count", cnt_of(exp_sel), k);
         chk("R9 partial nak", nak_of(exp_sel), 0);
         chk("R9 no ready when halted", int'(src_ready), 0);
         chk("R9 consumer in step", int'(cons_sel), exp_sel);
         release1();
         exp_sel = 1 - exp_sel;
      end

      // R8: tick coinciding with a byte
      rearm(1'b1, 2);
      tick_ms = 1'b1;
      push(5, exp_sel, 0, "R8 byte with tick");
      tick_ms = 1'b0;
      tick1();
      chk("R8 reload absorbed tick", int'(halted), 0);
      tick1();
      chk("R8 halt after full limit", int'(halted), 1);
      chk("R8 posted one byte", cnt_of(exp_sel), 1);
      release1();
      exp_sel = 1 - exp_sel;

      // R7: no counting before first byte
      rearm(1'b1, 0);
      repeat (4) tick1();
      chk("R7 no halt before first byte", int'(halted), 0);

      // R7: disabled timer never halts
      rearm(1'b0, 1);
      push(1, exp_sel, 0, "R7 disabled");
      push(2, exp_sel, 1, "R7 disabled");
      repeat (10) tick1();
      chk("R7 disabled no halt", int'(halted), 0);
      chk("R7 disabled still ready", int'(src_ready), 1);

      // R9: halt with empty buffer posts nothing
      rearm(1'b1, 1);
      for (int i = 0; i < PKT; i++) push(i, exp_sel, i, "R9 full block");
      chk("R9 block posted", nak_of(exp_sel), 0);
      tick1();
      chk("R9 empty halt", int'(halted), 1);
      chk("R9 empty no pulse", int'(partial_pulse), 0);
      chk("R9 other untouched", nak_of(1 - exp_sel), 1);
      release1();

      finish_run();
   end
endmodule